// File: doc/BRIEF.md
# Peripheral Interrupt Register Block

This block is the interrupt front end of a single peripheral. It watches eight raw interrupt lines. Each line is set up as a level or an edge detector through three configuration bits: type, high polarity and low polarity. Detected events are captured in a latched status register, but only while the line is enabled. A registered summary request is raised whenever any enabled line holds a latched event.

Software reaches the block through a small synchronous register port. The port has an 8-bit offset, 8-bit write data, write and read strobes, and combinational 8-bit read data. Enables are changed through separate write-one-to-set and write-one-to-clear offsets. Events are acknowledged through a write-one-to-clear offset. A test mode takes the eight line values from a software register in place of the real inputs, so the whole detection path can be exercised without external stimulus.

Top module: `periph_irq_regs`

## Requirements
- R1: After reset the type, both polarity, enable, latched, test-control, test-value, master-select and priority registers are all zero, and `summary_irq` is 0.
- R2: With type=1, pol_high=1, pol_low=0 (offsets 0x11/0x12/0x13, bit i for line i), a 0-to-1 change of a line sets its latched bit (read at 0x18) on the next clock edge. A line that stays high does not set it again after it is acknowledged.
- R3: With type=1, pol_high=0, pol_low=1, only a 1-to-0 change sets the latched bit. A rising change has no effect.
- R4: With type=1, pol_high=1, pol_low=1, both rising and falling changes set the latched bit.
- R5: With type=0, pol_high=1, pol_low=0, the latched bit is set on every cycle the line is high. An acknowledge written while the line is still high leaves the bit set, because a set wins over a clear in the same cycle.
- R6: With type=0, pol_high=0, pol_low=1, the latched bit is set while the line is low.
- R7: A line whose enable bit is 0 never sets its latched bit. Enabling it later does not capture an edge that happened while it was disabled.
- R8: Writing to offset 0x15 sets the enable bits where the data has 1s. Writing to offset 0x16 clears the enable bits where the data has 1s. Zero data bits change nothing. Reading 0x15 returns the enable mask, and reading 0x16 returns 0x00.
- R9: Writing 1s to offset 0x14 clears the matching latched bits when no new event hits them. Reading 0x14 returns 0x00.
- R10: Pending status (offset 0x19) equals latched AND enable. `summary_irq` is the OR of the pending bits, registered, so it follows pending one clock later.
- R11: When bit 7 of offset 0xE0 is 1, the value at offset 0xE1 replaces the real inputs, with bit 0 driving line 0, and the real inputs are ignored. Both test registers read back their stored values.
- R12: Offset 0x1A stores a 2-bit field in bits [1:0] and offset 0x1B stores one bit in bit 0. Undefined offsets read 0x00, and read data is 0x00 whenever the read strobe is low.
- R13: Offset 0x10 returns the current line values the detector sees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Raw interrupt lines, bit i is line i |
| reg_addr | input | 8 | Register offset within the peripheral window |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid in the cycle the read strobe is high |
| summary_irq | output | 1 | Registered OR of all pending bits |

## Verification
A wrong previous-value register or a wrong detector decode shows up at the latched-status offset one clock edge after the line changes. The bench reads that offset right after the edge, so the error appears at once. A corrupted enable or latch shows up in the pending read in the same cycle, and at `summary_irq` one edge later. This one-cycle lag is checked exactly, in both directions. An acknowledge that wrongly beats a set is exposed by a level line that is still active: it has to read back as set straight after the clear.

// File: rtl/periph_irq_regs.sv
module periph_irq_regs #(
  parameter int NL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] irq_in,
  input  logic [7:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic          reg_wr,
  input  logic          reg_rd,
  output logic [7:0]    reg_rdata,
  output logic          summary_irq
);
  localparam logic [7:0] A_RT = 8'h10, A_TYPE = 8'h11, A_POLH = 8'h12,
    A_POLL = 8'h13, A_ACK = 8'h14, A_ENS = 8'h15, A_ENC = 8'h16,
    A_LAT = 8'h18, A_PEND = 8'h19, A_MSEL = 8'h1A, A_PRIO = 8'h1B,
    A_TCTL = 8'hE0, A_TVAL = 8'hE1;

  logic [NL-1:0] type_q, polh_q, poll_q, en_q, lat_q, prev_q, tval_q;
  logic [1:0]    msel_q;
  logic          prio_q, test_q;

  logic [NL-1:0] src, rise, fall, hit, ack, pend;

  assign src  = test_q ? tval_q : irq_in;
  assign rise = src & ~prev_q;
  assign fall = ~src & prev_q;
  assign hit  = (type_q & ((polh_q & rise) | (poll_q & fall)))
              | (~type_q & ((polh_q & src) | (poll_q & ~src)));
  assign ack  = (reg_wr && reg_addr == A_ACK) ? reg_wdata[NL-1:0] : '0;
  assign pend = lat_q & en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      type_q <= '0; polh_q <= '0; poll_q <= '0; en_q <= '0;
      lat_q <= '0; prev_q <= '0; tval_q <= '0;
      msel_q <= '0; prio_q <= 1'b0; test_q <= 1'b0;
      summary_irq <= 1'b0;
    end else begin
      prev_q      <= src;
      lat_q       <= (lat_q & ~ack) | (hit & en_q);
      summary_irq <= |pend;
      if (reg_wr) begin
        case (reg_addr)
          A_TYPE: type_q <= reg_wdata[NL-1:0];
          A_POLH: polh_q <= reg_wdata[NL-1:0];
          A_POLL: poll_q <= reg_wdata[NL-1:0];
          A_ENS:  en_q   <= en_q | reg_wdata[NL-1:0];
          A_ENC:  en_q   <= en_q & ~reg_wdata[NL-1:0];
          A_MSEL: msel_q <= reg_wdata[1:0];
          A_PRIO: prio_q <= reg_wdata[0];
          A_TCTL: test_q <= reg_wdata[7];
          A_TVAL: tval_q <= reg_wdata[NL-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_rd) begin
      case (reg_addr)
        A_RT:   reg_rdata[NL-1:0] = src;
        A_TYPE: reg_rdata[NL-1:0] = type_q;
        A_POLH: reg_rdata[NL-1:0] = polh_q;
        A_POLL: reg_rdata[NL-1:0] = poll_q;
        A_ENS:  reg_rdata[NL-1:0] = en_q;
        A_LAT:  reg_rdata[NL-1:0] = lat_q;
        A_PEND: reg_rdata[NL-1:0] = pend;
        A_MSEL: reg_rdata[1:0]    = msel_q;
        A_PRIO: reg_rdata[0]      = prio_q;
        A_TCTL: reg_rdata[7]      = test_q;
        A_TVAL: reg_rdata[NL-1:0] = tval_q;
        default: reg_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/periph_irq_regs_chk.sv
module periph_irq_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_rdata,
  input logic       summary_irq,
  input logic [7:0] en,
  input logic [7:0] lat
);
  AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h15) |=> ((en & $past(reg_wdata)) == $past(reg_wdata))); // R8
  AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h16) |=> ((en & $past(reg_wdata)) == 8'h00)); // R8
  AST_NO_LATCH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat & ~$past(lat) & ~$past(en)) == 8'h00)); // R7
  AST_PEND_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 8'h19) |-> ((reg_rdata & ~en) == 8'h00)); // R10
  AST_SUMMARY_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (summary_irq == $past((lat & en) != 8'h00))); // R10
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> (reg_rdata == 8'h00)); // R12
endmodule

bind periph_irq_regs periph_irq_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .summary_irq(summary_irq), .en(en_q), .lat(lat_q)
);

// File: tb/periph_irq_regs_tb.sv
module periph_irq_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = 8'h00;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       summary_irq;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  periph_irq_regs u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .summary_irq(summary_irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    irq_in = 8'h00;
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    reg_rd = 1'b1;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic cfg(logic [7:0] t, logic [7:0] ph, logic [7:0] pl, logic [7:0] en);
    wr(8'h11, t);
    wr(8'h12, ph);
    wr(8'h13, pl);
    wr(8'h15, en);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    for (int a = 8'h11; a <= 8'h19; a++) begin
      rd(a[7:0], d);
      check("R1 reg", d, 8'h00);
    end
    rd(8'h1A, d); check("R1 msel", d, 8'h00);
    rd(8'h1B, d); check("R1 prio", d, 8'h00);
    rd(8'hE0, d); check("R1 test ctl", d, 8'h00);
    rd(8'hE1, d); check("R1 test val", d, 8'h00);
    check("R1 summary", {7'b0, summary_irq}, 8'h00);
  endtask

  task automatic t_rising();
    logic [7:0] d;
    do_reset();
    cfg(8'h01, 8'h01, 8'h00, 8'h01);
    irq_in = 8'h01;
    tick();
    rd(8'h18, d); check("R2 rise latch", d, 8'h01);
    check("R10 summary lag low", {7'b0, summary_irq}, 8'h00);
    tick();
    check("R10 summary high", {7'b0, summary_irq}, 8'h01);
    wr(8'h14, 8'h01);
    rd(8'h18, d); check("R9 ack clears", d, 8'h00);
    rd(8'h14, d); check("R9 ack reads zero", d, 8'h00);
    tick();
    check("R10 summary low", {7'b0, summary_irq}, 8'h00);
    tick();
    rd(8'h18, d); check("R2 steady high no relatch", d, 8'h00);
    irq_in = 8'h00;
    tick();
    rd(8'h18, d); check("R2 fall ignored", d, 8'h00);
  endtask

  task automatic t_falling();
    logic [7:0] d;
    do_reset();
    cfg(8'h02, 8'h00, 8'h02, 8'h02);
    irq_in = 8'h02;
    tick();
    rd(8'h18, d); check("R3 rise ignored", d, 8'h00);
    irq_in = 8'h00;
    tick();
    rd(8'h18, d); check("R3 fall latch", d, 8'h02);
  endtask

  task automatic t_both();
    logic [7:0] d;
    do_reset();
    cfg(8'h04, 8'h04, 8'h04, 8'h04);
    irq_in = 8'h04;
    tick();
    rd(8'h18, d); check("R4 rise latch", d, 8'h04);
    wr(8'h14, 8'h04);
    rd(8'h18, d); check("R4 acked", d, 8'h00);
    irq_in = 8'h00;
    tick();
    rd(8'h18, d); check("R4 fall latch", d, 8'h04);
  endtask

  task automatic t_level_high();
    logic [7:0] d;
    do_reset();
    cfg(8'h00, 8'h08, 8'h00, 8'h08);
    irq_in = 8'h08;
    tick();
    rd(8'h18, d); check("R5 level latch", d, 8'h08);
    wr(8'h14, 8'h08);
    rd(8'h18, d); check("R5 set beats clear", d, 8'h08);
    irq_in = 8'h00;
    tick();
    wr(8'h14, 8'h08);
    rd(8'h18, d); check("R5 clear after release", d, 8'h00);
  endtask

  task automatic t_level_low();
    logic [7:0] d;
    do_reset();
    irq_in = 8'h10;
    cfg(8'h00, 8'h00, 8'h10, 8'h10);
    tick();
    rd(8'h18, d); check("R6 high no latch", d, 8'h00);
    irq_in = 8'h00;
    tick();
    rd(8'h18, d); check("R6 low latch", d, 8'h10);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    do_reset();
    cfg(8'h20, 8'h20, 8'h00, 8'h00);
    irq_in = 8'h20;
    tick();
    irq_in = 8'h00;
    tick();
    rd(8'h18, d); check("R7 disabled no latch", d, 8'h00);
    wr(8'h15, 8'h20);
    tick();
    rd(8'h18, d); check("R7 old edge not captured", d, 8'h00);
  endtask

  task automatic t_enables();
    logic [7:0] d;
    do_reset();
    wr(8'h15, 8'h0F);
    rd(8'h15, d); check("R8 set", d, 8'h0F);
    wr(8'h16, 8'h05);
    rd(8'h15, d); check("R8 clear", d, 8'h0A);
    wr(8'h15, 8'h00);
    rd(8'h15, d); check("R8 zero set no effect", d, 8'h0A);
    wr(8'h16, 8'h00);
    rd(8'h15, d); check("R8 zero clear no effect", d, 8'h0A);
    rd(8'h16, d); check("R8 clear reads zero", d, 8'h00);
    wr(8'h16, 8'hFF);
    rd(8'h15, d); check("R8 clear all", d, 8'h00);
  endtask

  task automatic t_pending();
    logic [7:0] d;
    do_reset();
    cfg(8'h00, 8'h40, 8'h00, 8'h40);
    irq_in = 8'h40;
    tick();
    rd(8'h19, d); check("R10 pending set", d, 8'h40);
    tick();
    check("R10 summary set", {7'b0, summary_irq}, 8'h01);
    wr(8'h16, 8'h40);
    rd(8'h19, d); check("R10 pending masked", d, 8'h00);
    rd(8'h18, d); check("R10 latched kept", d, 8'h40);
    check("R10 summary one-cycle lag", {7'b0, summary_irq}, 8'h01);
    tick();
    check("R10 summary drops", {7'b0, summary_irq}, 8'h00);
  endtask

  task automatic t_test_mode();
    logic [7:0] d;
    do_reset();
    cfg(8'h00, 8'h01, 8'h00, 8'h01);
    wr(8'hE1, 8'h01);
    rd(8'h18, d); check("R11 inactive no latch", d, 8'h00);
    wr(8'hE0, 8'h80);
    tick();
    rd(8'h18, d); check("R11 injected latch", d, 8'h01);
    irq_in = 8'hFF;
    tick();
    rd(8'h10, d); check("R11 real inputs ignored", d, 8'h01);
    rd(8'hE0, d); check("R11 ctl readback", d, 8'h80);
    rd(8'hE1, d); check("R11 val readback", d, 8'h01);
  endtask

  task automatic t_misc();
    logic [7:0] d;
    do_reset();
    irq_in = 8'h5A;
    tick();
    rd(8'h10, d); check("R13 live status", d, 8'h5A);
    wr(8'h1A, 8'hFF);
    rd(8'h1A, d); check("R12 msel field", d, 8'h03);
    wr(8'h1B, 8'hFF);
    rd(8'h1B, d); check("R12 prio bit", d, 8'h01);
    rd(8'h17, d); check("R12 hole reads zero", d, 8'h00);
    rd(8'h50, d); check("R12 undefined reads zero", d, 8'h00);
    reg_addr = 8'h1A;
    #1 check("R12 idle read zero", reg_rdata, 8'h00);
  endtask

  initial begin
    t_reset();
    t_rising();
    t_falling();
    t_both();
    t_level_high();
    t_level_low();
    t_disabled();
    t_enables();
    t_pending();
    t_test_mode();
    t_misc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule